// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Decoder

This block claims a fixed 256-KB window in a 32-bit memory address space and routes accesses that fall inside it to a device's internal configuration storage. Software places the window by writing the upper address bits of a base register. A separate enable input, driven by another control register, must be set before any access can claim the window. Until configuration software sets that bit, every access misses.

Inside the window the offset selects one of four regions. A read-only header mirror returns a fixed identification pattern. A writable configuration mirror is backed by a small stub array. A large reserved hole reads as zero and ignores writes. A 256-byte scratch-pad can be read and written one dword at a time. Only full, aligned dword writes change state. Any other write is still acknowledged and changes nothing.

Each request gets exactly one response, one cycle later. The response carries a hit flag, and read data only for a read that hit the window.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset the base register reads 0, no response is pending, and every configuration and scratch-pad dword reads as zero.
- R2: A base register write stores data bits 31:18. On baseValue, bits 17:0 always read zero, and the low byte 00h is the scratch-pad size code for 256 bytes.
- R3: An access hits only when winEnable is 1 and reqAddr[31:18] equals the stored base bits. An access that misses leaves all state unchanged.
- R4: Every request cycle produces rspValid in the following cycle. rspHit reports the decode result. rspRdata is zero unless the access was a read that hit.
- R5: Offsets 00000h–0003Fh read as {HDR_TAG (16'h5A3C by default), 8'h00, offset[7:0] with bits 1:0 cleared}. Writes to this region have no effect.
- R6: Offsets 00040h–000FFh are 48 read/write dwords. Reads of this region return the last full dword written to it.
- R7: Offsets 00100h–3FEFFh are reserved. A read there hits and returns zero, and a write there is ignored.
- R8: Offsets 3FF00h–3FFFFh are a 64-dword scratch-pad that can be read and written.
- R9: A write changes state only if reqBe is 4'b1111 and reqAddr[1:0] is 0. Any other write that hits is acknowledged with rspHit set and changes nothing. A read ignores reqAddr[1:0] and returns the whole dword.
- R10: A new base value applies from the cycle after the base write. A request made in the same cycle as the base write is decoded against the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winEnable | input | 1 | Window claim enable from a separate control register |
| baseWrValid | input | 1 | Base register write strobe |
| baseWrData | input | 32 | Base register write data |
| baseValue | output | 32 | Current base register contents |
| reqValid | input | 1 | Request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Request byte address |
| reqBe | input | 4 | Request byte enables |
| reqWdata | input | 32 | Request write data |
| rspValid | output | 1 | Response valid, one cycle after a request |
| rspHit | output | 1 | The request hit the window |
| rspRdata | output | 32 | Read data, zero unless a read hit |

## Verification
A request presented before a rising edge has its response registered at that edge. The bench drives each request on a falling edge and samples rspValid, rspHit and rspRdata at the next falling edge. It drops the request in that same half cycle, so every response is matched to exactly one request. A base write shows on baseValue at the next falling edge. Storage effects, including writes that must have no effect, are checked through later reads, each against a bench model updated only after the response has been compared. The case of a request in the same cycle as a base write is driven directly, to show that the old base decodes that request and the new base decodes the one after it.

// File: rtl/cfg_win_pkg.sv
package cfg_win_pkg;
  localparam int WIN_LSB    = 18;             // window is 2**WIN_LSB bytes
  localparam int WORD_W     = 6;              // dword index within a 256-byte page
  localparam int HDR_BYTES  = 64;
  localparam int CFG_BYTES  = 256;            // end of writable mirror
  localparam int SCR_BYTES  = 256;
  localparam int CFG_FIRST  = HDR_BYTES / 4;
  localparam int CFG_LAST   = CFG_BYTES / 4 - 1;
  localparam int SCR_WORDS  = SCR_BYTES / 4;
  localparam logic [7:0] SCR_SIZE_CODE = 8'h00;

  typedef enum logic [1:0] {
    RG_HDR = 2'd0,
    RG_CFG = 2'd1,
    RG_RSV = 2'd2,
    RG_SCR = 2'd3
  } region_e;

  typedef struct packed {
    logic              take;
    logic              hit;
    logic              rd;
    logic              wrCfg;
    logic              wrScr;
    region_e           region;
    logic [WORD_W-1:0] word;
  } winStrobe_t;
endpackage

// File: rtl/cfg_win_ctrl.sv
module cfg_win_ctrl
  import cfg_win_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winEnable,
  input  logic              baseWrValid,
  input  logic [ADDR_W-1:0] baseWrData,
  output logic [ADDR_W-1:0] baseValue,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  output winStrobe_t        strb
);
  localparam int WIN_BYTES = 1 << WIN_LSB;
  localparam logic [WIN_LSB-1:0] HDR_END   = WIN_LSB'(HDR_BYTES);
  localparam logic [WIN_LSB-1:0] CFG_END   = WIN_LSB'(CFG_BYTES);
  localparam logic [WIN_LSB-1:0] SCR_START = WIN_LSB'(WIN_BYTES - SCR_BYTES);

  logic [ADDR_W-1:WIN_LSB] baseHi;
  logic [WIN_LSB-1:0]      offset;
  region_e                 region;
  logic                    fullDw;
  logic                    hit;
  logic                    unusedBaseLow;

  assign unusedBaseLow = ^baseWrData[WIN_LSB-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            baseHi <= '0;
    else if (baseWrValid) baseHi <= baseWrData[ADDR_W-1:WIN_LSB];
  end

  assign baseValue = {baseHi, {(WIN_LSB-8){1'b0}}, SCR_SIZE_CODE};

  assign offset = reqAddr[WIN_LSB-1:0];

  always_comb begin
    if (offset < HDR_END)         region = RG_HDR;
    else if (offset < CFG_END)    region = RG_CFG;
    else if (offset >= SCR_START) region = RG_SCR;
    else                          region = RG_RSV;
  end

  assign fullDw = (reqBe == 4'b1111) && (reqAddr[1:0] == 2'b00);
  assign hit    = reqValid && winEnable && (reqAddr[ADDR_W-1:WIN_LSB] == baseHi);

  always_comb begin
    strb.take   = reqValid;
    strb.hit    = hit;
    strb.rd     = hit && !reqWrite;
    strb.wrCfg  = hit && reqWrite && fullDw && (region == RG_CFG);
    strb.wrScr  = hit && reqWrite && fullDw && (region == RG_SCR);
    strb.region = region;
    strb.word   = offset[WORD_W+1:2];
  end

  AST_BASE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    baseWrValid |=> baseValue[ADDR_W-1:WIN_LSB] == $past(baseWrData[ADDR_W-1:WIN_LSB])); // R2
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !baseWrValid |=> $stable(baseValue)); // R10
  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCfg, strb.wrScr})); // R9
endmodule

// File: rtl/cfg_win_datapath.sv
module cfg_win_datapath
  import cfg_win_pkg::*;
#(
  parameter logic [15:0] HDR_TAG = 16'h5A3C
) (
  input  logic        clk,
  input  logic        rstN,
  input  winStrobe_t  strb,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic        rspHit,
  output logic [31:0] rspRdata
);
  logic [31:0] cfgMem [CFG_FIRST:CFG_LAST];
  logic [31:0] scrMem [0:SCR_WORDS-1];
  logic [31:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = CFG_FIRST; i <= CFG_LAST; i++) cfgMem[i] <= '0;
    end else if (strb.wrCfg) begin
      cfgMem[strb.word] <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SCR_WORDS; i++) scrMem[i] <= '0;
    end else if (strb.wrScr) begin
      scrMem[strb.word] <= reqWdata;
    end
  end

  always_comb begin
    case (strb.region)
      RG_HDR:  rdMux = {HDR_TAG, 8'h00, strb.word, 2'b00};
      RG_CFG:  rdMux = cfgMem[strb.word];
      RG_SCR:  rdMux = scrMem[strb.word];
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strb.take;
      rspHit   <= strb.hit;
      rspRdata <= strb.rd ? rdMux : '0;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> rspValid); // R4
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.take |=> !rspValid); // R4
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspRdata == 32'h0)); // R4
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.region == RG_RSV) |=> (rspRdata == 32'h0)); // R7
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfg_win_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter logic [15:0] HDR_TAG = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winEnable,
  input  logic              baseWrValid,
  input  logic [ADDR_W-1:0] baseWrData,
  output logic [ADDR_W-1:0] baseValue,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic              rspHit,
  output logic [31:0]       rspRdata
);
  winStrobe_t strb;

  cfg_win_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .winEnable(winEnable),
    .baseWrValid(baseWrValid), .baseWrData(baseWrData), .baseValue(baseValue),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe),
    .strb(strb)
  );

  cfg_win_datapath #(.HDR_TAG(HDR_TAG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspHit(rspHit), .rspRdata(rspRdata)
  );

  AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !winEnable) |=> (rspValid && !rspHit)); // R3
endmodule

// File: tb/sim_cfg_window_decoder.sv
`timescale 1ns/1ps
module sim_cfg_window_decoder;
  logic        clk = 1'b0;
  logic        rstN;
  logic        winEnable, baseWrValid, reqValid, reqWrite;
  logic [31:0] baseWrData, baseValue, reqAddr, reqWdata, rspRdata;
  logic [3:0]  reqBe;
  logic        rspValid, rspHit;

  always #2.5 clk = ~clk;

  cfg_window_decoder u0 (
    .clk(clk), .rstN(rstN), .winEnable(winEnable),
    .baseWrValid(baseWrValid), .baseWrData(baseWrData), .baseValue(baseValue),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspHit(rspHit), .rspRdata(rspRdata)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] cfgModel [16:63];
  logic [31:0] scrModel [0:63];
  logic [31:0] baseModel;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Region of a window offset: 0 header, 1 config, 2 reserved, 3 scratch
  function automatic int regionOf(logic [17:0] off);
    if (off < 18'h40)        return 0;
    else if (off < 18'h100)  return 1;
    else if (off >= 18'h3FF00) return 3;
    else                     return 2;
  endfunction

  function automatic logic [31:0] expRead(logic [31:0] a);
    case (regionOf(a[17:0]))
      0:       return {16'h5A3C, 8'h00, a[7:2], 2'b00};
      1:       return cfgModel[a[7:2]];
      3:       return scrModel[a[7:2]];
      default: return 32'h0;
    endcase
  endfunction

  task automatic access(bit wr, logic [31:0] a, logic [31:0] d, logic [3:0] be, bit en, string req);
    bit          expHit;
    logic [31:0] expData;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be; winEnable = en;
    expHit  = en && (a[31:18] == baseModel[31:18]);
    expData = (expHit && !wr) ? expRead(a) : 32'h0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(req, "rspValid", {31'b0, rspValid}, 32'h1);
    chk(req, "rspHit",   {31'b0, rspHit},   {31'b0, expHit});
    chk(req, "rspRdata", rspRdata, expData);
    if (expHit && wr && be == 4'hF && a[1:0] == 2'b00) begin
      if (regionOf(a[17:0]) == 1) cfgModel[a[7:2]] = d;
      if (regionOf(a[17:0]) == 3) scrModel[a[7:2]] = d;
    end
  endtask

  task automatic setBase(logic [31:0] v);
    @(negedge clk);
    baseWrValid = 1'b1; baseWrData = v;
    @(negedge clk);
    baseWrValid = 1'b0;
    baseModel = v & 32'hFFFC_0000;
    chk("R2", "baseValue", baseValue, baseModel);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] b, nb, a, d;
    logic [3:0]  be;
    bit          wr, en;
    int          pick;
    void'($urandom(32'd20517));
    rstN = 1'b0; winEnable = 1'b0; baseWrValid = 1'b0; baseWrData = '0;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqBe = '0; reqWdata = '0;
    for (int i = 16; i < 64; i++) cfgModel[i] = '0;
    for (int i = 0; i < 64; i++) scrModel[i] = '0;
    baseModel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "baseValue after reset", baseValue, 32'h0);
    chk("R1", "rspValid after reset", {31'b0, rspValid}, 32'h0);
    access(0, 32'h0003_FF00, 0, 4'hF, 1, "R1");
    access(0, 32'h0000_0040, 0, 4'hF, 1, "R1");

    setBase(32'h8A5F_FFFF);
    b = baseModel;

    // R5 header read and write
    access(0, b | 32'h0C, 0, 4'hF, 1, "R5");
    access(1, b | 32'h0C, 32'hDEAD_BEEF, 4'hF, 1, "R5");
    access(0, b | 32'h0C, 0, 4'hF, 1, "R5");
    access(0, b | 32'h3C, 0, 4'hF, 1, "R5");
    // R6 config region boundaries
    access(1, b | 32'h40, 32'h1111_2222, 4'hF, 1, "R6");
    access(1, b | 32'hFC, 32'h3333_4444, 4'hF, 1, "R6");
    access(0, b | 32'h40, 0, 4'hF, 1, "R6");
    access(0, b | 32'hFC, 0, 4'hF, 1, "R6");
    // R7 reserved
    access(1, b | 32'h100, 32'hAAAA_5555, 4'hF, 1, "R7");
    access(0, b | 32'h100, 0, 4'hF, 1, "R7");
    access(0, b | 32'h3FEFC, 0, 4'hF, 1, "R7");
    // R8 scratch-pad ends
    access(1, b | 32'h3FF00, 32'h0BAD_F00D, 4'hF, 1, "R8");
    access(1, b | 32'h3FFFC, 32'hCAFE_0001, 4'hF, 1, "R8");
    access(0, b | 32'h3FF00, 0, 4'hF, 1, "R8");
    access(0, b | 32'h3FFFC, 0, 4'hF, 1, "R8");
    // R9 partial and misaligned writes
    access(1, b | 32'h40, 32'h9999_9999, 4'b0111, 1, "R9");
    access(1, b | 32'h42, 32'h8888_8888, 4'hF, 1, "R9");
    access(1, b | 32'h3FF02, 32'h7777_7777, 4'hF, 1, "R9");
    access(0, b | 32'h40, 0, 4'hF, 1, "R9");
    access(0, b | 32'h3FF01, 0, 4'b0001, 1, "R9");
    // R3 disabled and outside-window accesses
    access(1, b | 32'h48, 32'h5555_1234, 4'hF, 0, "R3");
    access(1, (b ^ 32'h0004_0000) | 32'h48, 32'h6666_1234, 4'hF, 1, "R3");
    access(0, b | 32'h48, 0, 4'hF, 1, "R3");
    access(0, b | 32'h0C, 0, 4'hF, 0, "R3");

    // R10 request in the same cycle as a base write
    nb = 32'h1234_0000;
    @(negedge clk);
    baseWrValid = 1'b1; baseWrData = nb;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = b | 32'h40; reqBe = 4'hF; winEnable = 1'b1;
    @(negedge clk);
    baseWrValid = 1'b0; reqValid = 1'b0;
    chk("R10", "rspHit old base", {31'b0, rspHit}, 32'h1);
    chk("R10", "rspRdata old base", rspRdata, cfgModel[16]);
    baseModel = nb;
    chk("R10", "baseValue", baseValue, nb);
    access(0, b | 32'h40, 0, 4'hF, 1, "R10");
    access(0, nb | 32'h40, 0, 4'hF, 1, "R10");
    b = nb;

    // Random mix across all regions
    for (int n = 0; n < 600; n++) begin
      pick = $urandom % 5;
      case (pick)
        0: a = b | ($urandom % 32'h40);
        1: a = b | (32'h40 + $urandom % 32'hC0);
        2: a = b | (32'h100 + $urandom % 32'h3FE00);
        3: a = b | (32'h3FF00 + $urandom % 32'h100);
        default: a = (b ^ ((32'h1 + $urandom % 32'h3FFF) << 18)) | ($urandom % 32'h40000);
      endcase
      if ($urandom % 5 != 0) a[1:0] = 2'b00;
      be = ($urandom % 4 != 0) ? 4'hF : 4'($urandom);
      wr = $urandom % 2;
      en = ($urandom % 10) != 0;
      d  = $urandom;
      access(wr, a, d, be, en, "R4");
    end
    // Sweep reads to catch any stray state change
    for (int i = 16; i < 64; i++) access(0, b | (i * 4), 0, 4'hF, 1, "R6");
    for (int i = 0; i < 64; i++)  access(0, b | 32'h3FF00 | (i * 4), 0, 4'hF, 1, "R8");
    @(negedge clk);
    chk("R4", "rspValid idle", {31'b0, rspValid}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule